// File: doc/BRIEF.md
# Ripple-Block Carry Look-Ahead Adder

This is a purely combinational binary adder that adds two unsigned operands of a parameterised width and an incoming carry bit, giving a sum of the same width and a carry-out. Each operand bit forms a generate term (both bits set) and a propagate term (exactly one bit set). The operands are split into 4-bit groups. Within a group, all four carries come straight from those terms and the group's incoming carry through two-level look-ahead logic, so no carry ripples inside a group.

The groups are chained in series. Each group's top carry becomes the incoming carry of the next group up, and the highest group's top carry leaves the block as the carry-out. The operand width must be a whole multiple of four, and elaboration stops with an error when it is not. The block has no clock and no storage, and it is meant to sit inside a datapath wherever a medium-width addition with modest fan-in is needed.

Top module: `rbcla_adder`

## Requirements
- R1: For any operands and carry-in, {c_out, sum_o} equals the unsigned value op_a + op_b + c_in, computed at WIDTH+1 bits.
- R2: When every bit position only propagates (op_b equals the bitwise inverse of op_a), c_out equals c_in, and sum_o is all ones when c_in is 0 and all zeros when c_in is 1.
- R3: When every bit position generates (op_a and op_b both all ones), c_out is 1 and sum_o is all ones except bit 0, which equals c_in.
- R4: A carry leaving the lowest 4-bit group enters the next group: op_a = 0x0000000F, op_b = 0, c_in = 1 gives sum_o = 0x00000010 and c_out = 0.
- R5: The carry-out is the top carry of the highest group: with only bit WIDTH-1 set in both operands, c_out is 1 and sum_o equals c_in.
- R6: With both operands zero, sum_o equals c_in in bit 0 with all other bits zero, and c_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| c_in | input | 1 | Carry into the lowest bit |
| sum_o | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the highest bit |

## Verification
Every result of this block is due in the same clock period as the operands that produce it, because no register lies between any input and any output. The bench changes the operands on the falling edge of its reference clock and reads sum_o and c_out 5 ns later, after the carry chain has settled and well before the next rising edge. The expected values are formed in the bench with a plain WIDTH+1-bit addition, and the corner cases target the full propagate chain, the full generate case and the group-to-group carry hand-off.

// File: rtl/rbcla_adder.sv
module rbcla_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_out
);
  localparam int GRP  = 4;
  localparam int NGRP = WIDTH / GRP;

  if (WIDTH % GRP != 0 || WIDTH == 0) begin : g_bad_width
    $error("rbcla_adder: WIDTH must be a nonzero multiple of 4");
  end

  logic [WIDTH-1:0] gen, prop, cbit;
  logic [NGRP:0]    gc;

  assign gen   = op_a & op_b;
  assign prop  = op_a ^ op_b;
  assign gc[0] = c_in;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    logic [3:0] g, p;
    logic [4:0] c;
    assign g    = gen[k*GRP +: GRP];
    assign p    = prop[k*GRP +: GRP];
    assign c[0] = gc[k];
    assign c[1] = g[0] | (p[0] & c[0]);
    assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c[0]);
    assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                | (p[2] & p[1] & p[0] & c[0]);
    assign c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                | (p[3] & p[2] & p[1] & g[0])
                | (p[3] & p[2] & p[1] & p[0] & c[0]);
    assign cbit[k*GRP +: GRP] = c[3:0];
    assign gc[k+1] = c[4];
  end

  assign sum_o = prop ^ cbit;
  assign c_out = gc[NGRP];
endmodule

// File: rtl/rbcla_adder_chk.sv
module rbcla_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             c_in,
  input logic [WIDTH-1:0] sum_o,
  input logic             c_out
);
  localparam logic [WIDTH-1:0] ONES = '1;
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, c_in};

  always_comb begin
    a_r1_sum_matches: assert ({c_out, sum_o} == ref_sum);
    if ((op_a ^ op_b) == ONES)
      a_r2_all_prop: assert (c_out == c_in && sum_o == (c_in ? '0 : ONES));
    if ((op_a & op_b) == ONES)
      a_r3_all_gen: assert (c_out && sum_o[0] == c_in);
    if (op_a == '0 && op_b == '0)
      a_r6_zero_in: assert (!c_out && sum_o == {{(WIDTH-1){1'b0}}, c_in});
  end
endmodule

bind rbcla_adder rbcla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .c_in(c_in), .sum_o(sum_o), .c_out(c_out)
);

// File: tb/tb_rbcla_adder.sv
`timescale 1ns/1ps
module tb_rbcla_adder;
  localparam int W = 32;
  logic clk = 1'b0;
  logic [W-1:0] op_a, op_b, sum_o;
  logic c_in, c_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rbcla_adder #(.WIDTH(W)) dut (
    .op_a(op_a), .op_b(op_b), .c_in(c_in), .sum_o(sum_o), .c_out(c_out)
  );

  task automatic apply_check(input string req, input logic [W-1:0] a,
                             input logic [W-1:0] b, input logic ci,
                             input logic [W-1:0] exp_s, input logic exp_c);
    @(negedge clk);
    op_a = a; op_b = b; c_in = ci;
    #5;
    checks++;
    if (sum_o !== exp_s || c_out !== exp_c) begin
      failures++;
      $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b exp sum=%h cout=%b",
               req, a, b, ci, sum_o, c_out, exp_s, exp_c);
    end
  endtask

  task automatic ref_check(input string req, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic ci);
    logic [W:0] r;
    r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    apply_check(req, a, b, ci, r[W-1:0], r[W]);
  endtask

  task automatic t_r1_random();
    for (int i = 0; i < 40; i++)
      ref_check("R1", $urandom, $urandom, 1'($urandom));
  endtask

  task automatic t_r2_all_prop();
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] a;
      a = (i == 0) ? '0 : W'($urandom);
      apply_check("R2", a, ~a, 1'b0, '1, 1'b0);
      apply_check("R2", a, ~a, 1'b1, '0, 1'b1);
    end
  endtask

  task automatic t_r3_all_gen();
    apply_check("R3", '1, '1, 1'b0, {{(W-1){1'b1}}, 1'b0}, 1'b1);
    apply_check("R3", '1, '1, 1'b1, '1, 1'b1);
  endtask

  task automatic t_r4_handoff();
    apply_check("R4", 32'h0000_000F, '0, 1'b1, 32'h0000_0010, 1'b0);
    apply_check("R4", 32'h0000_0FFF, 32'h0000_0001, 1'b0, 32'h0000_1000, 1'b0);
    apply_check("R4", 32'h0FFF_FFFF, '0, 1'b1, 32'h1000_0000, 1'b0);
  endtask

  task automatic t_r5_top_carry();
    apply_check("R5", 32'h8000_0000, 32'h8000_0000, 1'b0, '0, 1'b1);
    apply_check("R5", 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0000_0001, 1'b1);
    apply_check("R5", 32'hF000_0000, 32'h1000_0000, 1'b0, '0, 1'b1);
  endtask

  task automatic t_r6_zero();
    apply_check("R6", '0, '0, 1'b0, '0, 1'b0);
    apply_check("R6", '0, '0, 1'b1, 32'h0000_0001, 1'b0);
  endtask

  initial begin
    op_a = '0; op_b = '0; c_in = 1'b0;
    t_r6_zero();
    t_r1_random();
    t_r2_all_prop();
    t_r3_all_gen();
    t_r4_handoff();
    t_r5_top_carry();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule